// File: doc/BRIEF.md
# ECC-Protected Memory Word Path

This block sits between a requester that works in 64-bit words with per-byte enables and a memory array that stores 72-bit words. On every write it adds eight check bits. On every read it checks the stored word. In correcting mode it repairs single-bit errors. In detect-only mode it reports errors without touching the data. If a write does not cover all eight bytes while protection is on, the block runs a read-modify-write by itself. It reads the stored word, repairs it if it can, merges the new bytes, re-encodes the word and writes it back.

Requests use a valid/ready handshake, and each request gets exactly one single-cycle response pulse. The memory side is a simple synchronous port: a request is valid/ready, and read data returns later with its own valid strobe. Sticky status flags keep a record of single and multiple errors. The syndrome and word address of the first error since the last clear are also captured.

Top module: `ecc_mem_path`

## Requirements
- R1: With protection on, every memory write carries the 64 data bits in bits [63:0] and the check byte in bits [71:64], with all nine enables set (`mem_req_be` = 9'h1FF, where bit k covers byte k and bit 8 covers the check byte). A full 8-byte write makes one memory write and no memory read.
- R2: A read of a word stored without errors returns the written data with `rsp_err` low and leaves the status flags clear.
- R3: In correcting mode (`corr_en`=1), a read with one flipped data or check bit returns the original data with `rsp_err` low and sets `sts_single`.
- R4: In detect-only mode (`corr_en`=0), a read with a single-bit error returns the stored data bits unmodified, raises `rsp_err` and sets `sts_single`.
- R5: In either mode, a read with two flipped bits raises `rsp_err` and sets `sts_multi`.
- R6: The syndrome is 8 bits. Bit 7 is the parity over all 72 stored bits: 1 means a single error and 0 with a nonzero value means a double error. Bits [6:0] locate the bit. A flip of stored bit 71 alone gives exactly 8'h80.
- R7: With protection on, a write with byte enables other than 8'hFF makes exactly one memory read and then one full memory write. Enabled bytes come from the request and the other bytes come from the stored word after correction, so a later read returns the merged word with no error.
- R8: If the read phase of a read-modify-write finds a double error, no memory write takes place and the response has `rsp_err` high.
- R9: With protection off (`ecc_en`=0), partial writes go to memory without a read, with `mem_req_be` = {1'b0, byte enables}. Reads return the raw stored data bits with `rsp_err` low and leave the status unchanged.
- R10: `sts_single` and `sts_multi` stay set until `sts_clr` is pulsed, and a pulse clears the flags, the syndrome and the address. The syndrome and address are loaded only by the first error seen while both flags are clear.
- R11: `req_ready` drops in the cycle after a request is accepted and stays low until that request's single-cycle `rsp_valid` pulse, including through a whole read-modify-write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ecc_en | input | 1 | Protection on: encode, check, read-modify-write |
| corr_en | input | 1 | Correct single errors (1) or only report them (0) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables of a write |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | 64 | Read data |
| rsp_err | output | 1 | Error response |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | Memory write (1) or read (0) |
| mem_req_addr | output | ADDR_W | Memory word address |
| mem_req_wdata | output | 72 | Stored word: check byte and data |
| mem_req_be | output | 9 | Memory byte enables, bit 8 = check byte |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_rdata | input | 72 | Memory read data |
| sts_clr | input | 1 | Pulse to clear status |
| sts_single | output | 1 | Sticky single-error flag |
| sts_multi | output | 1 | Sticky double-error flag |
| sts_syndrome | output | 8 | Syndrome of first error |
| sts_addr | output | ADDR_W | Word address of first error |

## Verification
The assertions take `ecc_en` and `corr_en` as steady while a request is in flight, so the write-enable checks can read them at the memory port. They also take the memory port as returning exactly one read response for each accepted read. The stimulus changes the mode inputs only between requests, when the block is idle. Its memory model answers each accepted read one cycle later and stalls `mem_req_ready` on a fixed pattern. Bit errors are injected into the stored words only while no request is pending.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W  = 64;
    localparam int CHK_W   = 8;
    localparam int WORD_W  = DATA_W + CHK_W;
    localparam int NBYTES  = DATA_W / 8;
    localparam int POS_W   = CHK_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_REQ,
        ST_RD_WAIT,
        ST_MRG_REQ,
        ST_MRG_WAIT,
        ST_WR_REQ,
        ST_RESP
    } path_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [CHK_W-1:0]  syn;
        logic              sgl;
        logic              dbl;
    } chk_res_t;

    // Hamming position of data bit j: the j-th integer from 3 upward
    // that is not a power of two.
    function automatic int unsigned pos_of(input int unsigned j);
        int unsigned cnt;
        int unsigned res;
        cnt = 0;
        res = 0;
        for (int unsigned p = 3; p < 128; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (cnt == j) res = p;
                cnt = cnt + 1;
            end
        end
        return res;
    endfunction

    function automatic logic [POS_W-1:0] pos_bits(input logic [DATA_W-1:0] d);
        logic [POS_W-1:0] c;
        int unsigned      p;
        c = '0;
        for (int unsigned j = 0; j < DATA_W; j++) begin
            p = pos_of(j);
            if (d[j]) c = c ^ p[POS_W-1:0];
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [POS_W-1:0] c;
        c = pos_bits(d);
        return {^{c, d}, c, d};
    endfunction

    function automatic logic [DATA_W-1:0] byte_merge(input logic [DATA_W-1:0] old_d,
                                                     input logic [DATA_W-1:0] new_d,
                                                     input logic [NBYTES-1:0] be);
        logic [DATA_W-1:0] m;
        for (int b = 0; b < NBYTES; b++)
            m[b*8 +: 8] = be[b] ? new_d[b*8 +: 8] : old_d[b*8 +: 8];
        return m;
    endfunction

endpackage

// File: rtl/ecc_check.sv
module ecc_check
    import ecc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output chk_res_t          res
);

    logic [POS_W-1:0]  pos_syn;
    logic              overall;
    logic [DATA_W-1:0] flip;

    assign pos_syn = pos_bits(word[DATA_W-1:0]) ^ word[WORD_W-2:DATA_W];
    assign overall = ^word;

    for (genvar g = 0; g < DATA_W; g++) begin : g_fix
        localparam int unsigned P = pos_of(g);
        assign flip[g] = overall && (pos_syn == P[POS_W-1:0]);
    end

    always_comb begin
        res.data = word[DATA_W-1:0] ^ flip;
        res.syn  = {overall, pos_syn};
        res.sgl  = overall;
        res.dbl  = !overall && (pos_syn != '0);
    end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt,
    input  chk_res_t          res,
    input  logic [ADDR_W-1:0] addr,
    input  logic              clr,
    output logic              flag_sgl,
    output logic              flag_dbl,
    output logic [CHK_W-1:0]  cap_syn,
    output logic [ADDR_W-1:0] cap_addr
);

    logic base_sgl, base_dbl, hit;

    always_comb begin
        base_sgl = clr ? 1'b0 : flag_sgl;
        base_dbl = clr ? 1'b0 : flag_dbl;
        hit      = evt && (res.sgl || res.dbl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_sgl <= 1'b0;
            flag_dbl <= 1'b0;
            cap_syn  <= '0;
            cap_addr <= '0;
        end else begin
            flag_sgl <= base_sgl || (evt && res.sgl);
            flag_dbl <= base_dbl || (evt && res.dbl);
            if (hit && !base_sgl && !base_dbl) begin
                cap_syn  <= res.syn;
                cap_addr <= addr;
            end else if (clr) begin
                cap_syn  <= '0;
                cap_addr <= '0;
            end
        end
    end

    AST_SGL_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_sgl && !clr |=> flag_sgl); // R10
    AST_DBL_STICKY: assert property (@(posedge clk) disable iff (rst)
        flag_dbl && !clr |=> flag_dbl); // R10
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        (flag_sgl || flag_dbl) && !clr |=> $stable(cap_addr) && $stable(cap_syn)); // R10

endmodule

// File: rtl/ecc_mem_path.sv
module ecc_mem_path
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ecc_en,
    input  logic                corr_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [NBYTES-1:0]   req_be,
    output logic                rsp_valid,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_err,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic                mem_req_write,
    output logic [ADDR_W-1:0]   mem_req_addr,
    output logic [WORD_W-1:0]   mem_req_wdata,
    output logic [NBYTES:0]     mem_req_be,
    input  logic                mem_rsp_valid,
    input  logic [WORD_W-1:0]   mem_rsp_rdata,
    input  logic                sts_clr,
    output logic                sts_single,
    output logic                sts_multi,
    output logic [CHK_W-1:0]    sts_syndrome,
    output logic [ADDR_W-1:0]   sts_addr
);

    path_state_e        st;
    logic [ADDR_W-1:0]  r_addr;
    logic [DATA_W-1:0]  r_wdata;
    logic [NBYTES-1:0]  r_be;
    logic [DATA_W-1:0]  r_rdata;
    logic               r_err;
    logic [WORD_W-1:0]  wr_word;
    logic [NBYTES:0]    wr_be;
    chk_res_t           chk;
    logic               chk_evt;

    ecc_check u_check (
        .word (mem_rsp_rdata),
        .res  (chk)
    );

    assign chk_evt = mem_rsp_valid && ecc_en &&
                     ((st == ST_RD_WAIT) || (st == ST_MRG_WAIT));

    ecc_err_log #(.ADDR_W(ADDR_W)) u_log (
        .clk      (clk),
        .rst      (rst),
        .evt      (chk_evt),
        .res      (chk),
        .addr     (r_addr),
        .clr      (sts_clr),
        .flag_sgl (sts_single),
        .flag_dbl (sts_multi),
        .cap_syn  (sts_syndrome),
        .cap_addr (sts_addr)
    );

    always_comb begin
        req_ready     = (st == ST_IDLE);
        rsp_valid     = (st == ST_RESP);
        rsp_rdata     = r_rdata;
        rsp_err       = r_err;
        mem_req_valid = (st == ST_RD_REQ) || (st == ST_MRG_REQ) || (st == ST_WR_REQ);
        mem_req_write = (st == ST_WR_REQ);
        mem_req_addr  = r_addr;
        mem_req_wdata = wr_word;
        mem_req_be    = wr_be;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            r_addr  <= '0;
            r_wdata <= '0;
            r_be    <= '0;
            r_rdata <= '0;
            r_err   <= 1'b0;
            wr_word <= '0;
            wr_be   <= '0;
        end else begin
            case (st)
                ST_IDLE: if (req_valid) begin
                    r_addr  <= req_addr;
                    r_wdata <= req_wdata;
                    r_be    <= req_be;
                    r_err   <= 1'b0;
                    if (!req_write) begin
                        st <= ST_RD_REQ;
                    end else if (ecc_en && (req_be != '1)) begin
                        st <= ST_MRG_REQ;
                    end else begin
                        wr_word <= ecc_en ? ecc_encode(req_wdata)
                                          : {{CHK_W{1'b0}}, req_wdata};
                        wr_be   <= ecc_en ? '1 : {1'b0, req_be};
                        st      <= ST_WR_REQ;
                    end
                end
                ST_RD_REQ:  if (mem_req_ready) st <= ST_RD_WAIT;
                ST_MRG_REQ: if (mem_req_ready) st <= ST_MRG_WAIT;
                ST_RD_WAIT: if (mem_rsp_valid) begin
                    r_rdata <= (ecc_en && corr_en) ? chk.data : mem_rsp_rdata[DATA_W-1:0];
                    r_err   <= ecc_en && (chk.dbl || (chk.sgl && !corr_en));
                    st      <= ST_RESP;
                end
                ST_MRG_WAIT: if (mem_rsp_valid) begin
                    if (chk.dbl) begin
                        r_err <= 1'b1;
                        st    <= ST_RESP;
                    end else begin
                        wr_word <= ecc_encode(byte_merge(chk.data, r_wdata, r_be));
                        wr_be   <= '1;
                        st      <= ST_WR_REQ;
                    end
                end
                ST_WR_REQ: if (mem_req_ready) st <= ST_RESP;
                default:   st <= ST_IDLE;
            endcase
        end
    end

    AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> !req_ready); // R11
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R11
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
                                            && $stable(mem_req_write)); // R11
    AST_FULL_ENABLES: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write && ecc_en |-> mem_req_be == '1); // R1
    AST_OFF_NO_CHECK: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && mem_req_write && !ecc_en |-> !mem_req_be[NBYTES]); // R9
    AST_DBL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MRG_WAIT) && mem_rsp_valid && chk.dbl |=> !mem_req_valid && rsp_err); // R8

endmodule

// File: tb/ecc_mem_path_tb.sv
module ecc_mem_path_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ecc_en = 1'b1, corr_en = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic [7:0]  req_be = '0;
    logic        req_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mem_req_valid, mem_req_ready, mem_req_write;
    logic [AW-1:0] mem_req_addr;
    logic [71:0] mem_req_wdata;
    logic [8:0]  mem_req_be;
    logic        mem_rsp_valid = 1'b0;
    logic [71:0] mem_rsp_rdata = '0;
    logic        sts_clr = 1'b0, sts_single, sts_multi;
    logic [7:0]  sts_syndrome;
    logic [AW-1:0] sts_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_mem_path #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .ecc_en(ecc_en), .corr_en(corr_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
        .sts_clr(sts_clr), .sts_single(sts_single), .sts_multi(sts_multi),
        .sts_syndrome(sts_syndrome), .sts_addr(sts_addr)
    );

    // memory model: one-cycle read latency, stalls one cycle in three
    logic [71:0] marr [16];
    int          cyc = 0, rd_cnt = 0, wr_cnt = 0;
    logic [8:0]  last_be = '0;
    logic        inj_req = 1'b0;
    logic [3:0]  inj_addr = '0;
    logic [71:0] inj_mask = '0;

    assign mem_req_ready = (cyc % 3) != 2;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        if (inj_req) marr[inj_addr] <= marr[inj_addr] ^ inj_mask;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                for (int b = 0; b < 9; b++)
                    if (mem_req_be[b]) marr[mem_req_addr[3:0]][b*8 +: 8] <= mem_req_wdata[b*8 +: 8];
                wr_cnt  <= wr_cnt + 1;
                last_be <= mem_req_be;
            end else begin
                mem_rsp_rdata <= marr[mem_req_addr[3:0]];
                mem_rsp_valid <= 1'b1;
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    typedef struct {
        bit          ck_data;
        logic [63:0] d;
        bit          e;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected response", {8'h0, rsp_rdata}, '0);
            end else begin
                exp_t x;
                x = exp_q.pop_front();
                check(rsp_err == x.e, {x.tag, " err"}, {71'h0, rsp_err}, {71'h0, x.e});
                if (x.ck_data)
                    check(rsp_rdata == x.d, {x.tag, " data"}, {8'h0, rsp_rdata}, {8'h0, x.d});
            end
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [63:0] d,
                         input logic [7:0] be, input bit ck, input logic [63:0] ed,
                         input bit ee, input string tag);
        exp_t x;
        x.ck_data = ck; x.d = ed; x.e = ee; x.tag = tag;
        exp_q.push_back(x);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R11 ready low after accept", {71'h0, req_ready}, '0);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic inject(input logic [3:0] a, input logic [71:0] m);
        @(negedge clk);
        inj_req = 1'b1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_req = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    localparam logic [63:0] D1 = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] D2 = 64'hFEDC_BA98_7654_3210;
    localparam logic [63:0] D3 = 64'hA5A5_5A5A_0F0F_F0F0;
    localparam logic [63:0] D4 = 64'h1111_2222_3333_4444;
    localparam logic [63:0] D5 = 64'hCAFE_F00D_DEAD_BEEF;

    initial begin
        int r0, w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(req_ready && !rsp_valid && !mem_req_valid && !sts_single && !sts_multi,
              "reset state", {67'h0, req_ready, rsp_valid, mem_req_valid, sts_single, sts_multi},
              {67'h0, 5'b10000});

        // R1 full writes: one write, no read, all enables
        r0 = rd_cnt; w0 = wr_cnt;
        issue(1, 1, D1, 8'hFF, 0, '0, 0, "R1 full write");
        check(rd_cnt == r0 && wr_cnt == w0 + 1, "R1 access counts", {40'h0, 16'(rd_cnt), 16'(wr_cnt)},
              {40'h0, 16'(r0), 16'(w0 + 1)});
        check(last_be == 9'h1FF, "R1 enables", {63'h0, last_be}, {63'h0, 9'h1FF});
        issue(1, 2, D2, 8'hFF, 0, '0, 0, "R1 full write");
        issue(1, 3, D3, 8'hFF, 0, '0, 0, "R1 full write");
        issue(1, 4, D4, 8'hFF, 0, '0, 0, "R1 full write");
        issue(1, 5, D5, 8'hFF, 0, '0, 0, "R1 full write");
        issue(1, 6, 64'h0, 8'hFF, 0, '0, 0, "R1 full write");

        // R2 clean read
        issue(0, 1, '0, '0, 1, D1, 0, "R2 clean read");
        check(!sts_single && !sts_multi, "R2 status clear", {70'h0, sts_single, sts_multi}, '0);

        // R3 / R6 / R10 single error corrected
        inject(1, 72'h20);
        issue(0, 1, '0, '0, 1, D1, 0, "R3 corrected read");
        check(sts_single && !sts_multi, "R3 single flag", {70'h0, sts_single, sts_multi}, {70'h0, 2'b10});
        check(sts_syndrome[7] && sts_syndrome[6:0] != 0, "R6 single syndrome", {64'h0, sts_syndrome}, {64'h0, 8'h80});
        check(sts_addr == 1, "R10 first address", {62'h0, sts_addr}, {62'h0, 10'd1});
        inject(2, 72'h1 << 40);
        issue(0, 2, '0, '0, 1, D2, 0, "R3 corrected read");
        check(sts_addr == 1, "R10 address kept", {62'h0, sts_addr}, {62'h0, 10'd1});
        clear_sts();
        check(!sts_single && !sts_multi && sts_syndrome == 0 && sts_addr == 0, "R10 clear",
              {52'h0, sts_single, sts_multi, sts_syndrome, sts_addr}, '0);

        // R4 detect-only
        corr_en = 1'b0;
        issue(0, 1, '0, '0, 1, D1 ^ 64'h20, 1, "R4 detect-only read");
        check(sts_single, "R4 single flag", {71'h0, sts_single}, {71'h0, 1'b1});
        corr_en = 1'b1;
        clear_sts();

        // R5 double error
        inject(3, 72'h204);
        issue(0, 3, '0, '0, 0, '0, 1, "R5 double read");
        check(sts_multi && !sts_single, "R5 multi flag", {70'h0, sts_single, sts_multi}, {70'h0, 2'b01});
        check(!sts_syndrome[7] && sts_syndrome != 0, "R6 double syndrome", {64'h0, sts_syndrome}, {64'h0, 8'h7F});
        clear_sts();

        // R6 top check bit
        inject(4, {8'h80, 64'h0});
        issue(0, 4, '0, '0, 1, D4, 0, "R6 top bit read");
        check(sts_syndrome == 8'h80, "R6 top bit syndrome", {64'h0, sts_syndrome}, {64'h0, 8'h80});
        clear_sts();

        // R7 read-modify-write
        r0 = rd_cnt; w0 = wr_cnt;
        issue(1, 5, 64'h0000_0000_1234_5678, 8'h0F, 0, '0, 0, "R7 partial write");
        check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R7 access counts", {40'h0, 16'(rd_cnt), 16'(wr_cnt)},
              {40'h0, 16'(r0 + 1), 16'(w0 + 1)});
        issue(0, 5, '0, '0, 1, 64'hCAFE_F00D_1234_5678, 0, "R7 merged read");
        issue(1, 1, 64'h9999_8888_0000_0000, 8'hF0, 0, '0, 0, "R7 merge on single error");
        clear_sts();
        issue(0, 1, '0, '0, 1, 64'h9999_8888_89AB_CDEF, 0, "R7 repaired merged read");
        check(!sts_single && !sts_multi, "R7 re-encoded clean", {70'h0, sts_single, sts_multi}, '0);

        // R8 abort on double error
        r0 = rd_cnt; w0 = wr_cnt;
        issue(1, 3, 64'hFF, 8'h01, 0, '0, 1, "R8 aborted partial write");
        check(wr_cnt == w0 && rd_cnt == r0 + 1, "R8 no write-back", {40'h0, 16'(rd_cnt), 16'(wr_cnt)},
              {40'h0, 16'(r0 + 1), 16'(w0)});
        issue(0, 3, '0, '0, 0, '0, 1, "R8 word untouched");
        clear_sts();

        // R9 protection off
        ecc_en = 1'b0;
        r0 = rd_cnt;
        issue(1, 6, 64'hBEEF, 8'h03, 0, '0, 0, "R9 pass-through write");
        check(rd_cnt == r0 && last_be == 9'h003, "R9 no read, data enables", {47'h0, 16'(rd_cnt), last_be},
              {47'h0, 16'(r0), 9'h003});
        issue(0, 6, '0, '0, 1, 64'hBEEF, 0, "R9 raw read");
        issue(0, 3, '0, '0, 1, D3 ^ 64'h204, 0, "R9 unchecked read");
        check(!sts_single && !sts_multi, "R9 status untouched", {70'h0, sts_single, sts_multi}, '0);

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R11 run hung actual=%0d expected=0", exp_q.size());
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule